// File: doc/BRIEF.md
# Power Gating Opportunity Monitor

This block watches one activity bit per clock from an execution unit and measures how many cycles that unit could have spent powered off if sleep entry and exit were predicted perfectly. Every sleep episode has a fixed cost in cycles, made up of the wake-up latency plus the break-even time. An idle stretch therefore earns credit only for the cycles it lasts beyond that cost. Stretches that do not outlast the cost earn nothing.

Software opens a measurement window with a start pulse. The start pulse also captures the per-episode cost. Software closes the window with an end pulse. It then reads two counters: all cycles observed in the window, and the creditable opportunity cycles. Software forms the ratio itself. A one-cycle done pulse shows that the final credit has landed and that both counters are settled.

Top module: `pg_opportunity_monitor`

## Requirements
- R1: After reset both counters read 0 and `done_o` is low.
- R2: A cycle with `win_start_i` high clears both counters and the idle-run length. The window then counts from the next cycle onward, and the start cycle itself is not counted.
- R3: `total_o` grows by one for every cycle strictly between the start cycle and the end cycle.
- R4: `busy_i` = 1 marks a busy cycle and 0 an idle cycle. A busy cycle closes the current idle run. If the run is longer than the captured overhead, `opp_o` grows by the run length minus the overhead. A run of at most the overhead adds nothing.
- R5: An idle run still open when `win_end_i` is sampled is closed at that point and credited under the R4 rule.
- R6: The overhead is taken from `overhead_i` in the start cycle. Changes to `overhead_i` during the window have no effect.
- R7: `done_o` is high for exactly one cycle, the cycle after `win_end_i` is sampled in an open window. Both counters hold their final values by then.
- R8: While no window is open, `busy_i` has no effect and both counters hold their values.
- R9: The idle-run counter saturates at 2^RUN_W-1. Both accumulators saturate at their maximum instead of wrapping.
- R10: `win_start_i` during an open window restarts the window with cleared state. If `win_start_i` and `win_end_i` are high together, the start wins and no done pulse follows.
- R11: `win_end_i` with no window open is ignored: no done pulse and no counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Unit activity this cycle (1 busy, 0 idle) |
| overhead_i | input | OVH_W | Per-episode cost in cycles (wake-up plus break-even) |
| win_start_i | input | 1 | Open (or restart) a measurement window |
| win_end_i | input | 1 | Close the measurement window |
| total_o | output | ACC_W | Cycles observed in the window |
| opp_o | output | ACC_W | Creditable power-gating opportunity cycles |
| done_o | output | 1 | One-cycle pulse after the window closes |

## Verification
The hardest case to reach is run-length saturation. It needs an idle stretch longer than 2^RUN_W cycles inside one window, so that the clamped run, not the true length, is what gets credited. The bench reaches it by holding `busy_i` low for 70,000 cycles with zero overhead and then ending the run with one busy cycle. At that point `opp_o` must read exactly 65,535, while `total_o` still counts every cycle. A second subtle case is restarting mid-run. The bench restarts the window in the middle of an idle stretch, so a run length left over from before the restart would show up as extra credit.

// File: rtl/pgom_pkg.sv
// Package: shared types for the power gating opportunity monitor.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pgom_pkg;
    // Window control state: either waiting for a start or measuring.
    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;
endpackage

// File: rtl/pgom_run_tracker.sv
// Module: pgom_run_tracker
// Counts the length of the current idle run, saturating at its maximum,
// and presents the credit that run would earn against the per-episode cost.
// Assumes: RUN_W > OVH_W; clear and close both zero the run; clear wins.
module pgom_run_tracker #(
    parameter int RUN_W = 16,
    parameter int OVH_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             close,
    input  logic             step_idle,
    input  logic [OVH_W-1:0] ovh,
    output logic [RUN_W-1:0] run_len,
    output logic [RUN_W-1:0] credit
);
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    logic [RUN_W-1:0] ovh_ext;

    assign ovh_ext = {{(RUN_W-OVH_W){1'b0}}, ovh};

    // Run-length register: clears on window start or run close, else counts idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (clear || close) begin
            run_len <= '0;
        end else if (step_idle && (run_len != RUN_MAX)) begin
            run_len <= run_len + 1'b1;
        end
    end

    // Credit of the current run: cycles beyond the overhead, or zero.
    always_comb begin
        if (run_len > ovh_ext) begin
            credit = run_len - ovh_ext;
        end else begin
            credit = '0;
        end
    end
endmodule

// File: rtl/pgom_sat_acc.sv
// Module: pgom_sat_acc
// Saturating accumulator: clears synchronously, adds a value when enabled,
// and clamps at all-ones instead of wrapping.
// Assumes: clear has priority over add.
module pgom_sat_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] sum
);
    localparam logic [W-1:0] SUM_MAX = {W{1'b1}};

    logic [W:0] wide_sum;

    // Full-width sum to expose the carry used for clamping.
    always_comb begin
        wide_sum = {1'b0, sum} + {1'b0, add_val};
    end

    // Accumulator register with clear priority and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (add_en) begin
            if (wide_sum[W]) begin
                sum <= SUM_MAX;
            end else begin
                sum <= wide_sum[W-1:0];
            end
        end
    end
endmodule

// File: rtl/pg_opportunity_monitor.sv
// Module: pg_opportunity_monitor (top)
// Measures, over a software-delimited window, the total cycles and the
// cycles an execution unit could have been power gated under ideal
// prediction, charging a fixed overhead per sleep episode.
// Assumes: ACC_W > RUN_W > OVH_W; start and end are single-cycle pulses;
// the start and end cycles are not themselves counted.
module pg_opportunity_monitor
    import pgom_pkg::*;
#(
    parameter int RUN_W = 16,
    parameter int ACC_W = 32,
    parameter int OVH_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [OVH_W-1:0] overhead_i,
    input  logic             win_start_i,
    input  logic             win_end_i,
    output logic [ACC_W-1:0] total_o,
    output logic [ACC_W-1:0] opp_o,
    output logic             done_o
);
    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    win_state_t       state_q;
    logic [OVH_W-1:0] ovh_q;
    logic             is_open;
    logic             sample;
    logic             close_evt;
    logic             finish;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] credit;
    logic [ACC_W-1:0] credit_ext;
    logic             credit_nz;

    // Derive per-cycle control from window state and the pulse inputs.
    always_comb begin
        is_open    = (state_q == WIN_OPEN);
        sample     = is_open && !win_start_i && !win_end_i;
        close_evt  = is_open && !win_start_i && (win_end_i || busy_i);
        finish     = is_open && !win_start_i && win_end_i;
        credit_ext = {{(ACC_W-RUN_W){1'b0}}, credit};
        credit_nz  = (credit != '0);
    end

    // Window state: start opens (or reopens), end closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_CLOSED;
        end else if (win_start_i) begin
            state_q <= WIN_OPEN;
        end else if (win_end_i) begin
            state_q <= WIN_CLOSED;
        end
    end

    // Overhead capture: latched once per window at the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovh_q <= '0;
        end else if (win_start_i) begin
            ovh_q <= overhead_i;
        end
    end

    // Done pulse: one cycle after a valid window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= finish;
        end
    end

    pgom_run_tracker #(
        .RUN_W (RUN_W),
        .OVH_W (OVH_W)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (win_start_i),
        .close     (close_evt),
        .step_idle (sample && !busy_i),
        .ovh       (ovh_q),
        .run_len   (run_len),
        .credit    (credit)
    );

    pgom_sat_acc #(
        .W (ACC_W)
    ) u_total (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_start_i),
        .add_en  (sample),
        .add_val (ONE),
        .sum     (total_o)
    );

    pgom_sat_acc #(
        .W (ACC_W)
    ) u_opp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (win_start_i),
        .add_en  (close_evt && credit_nz),
        .add_val (credit_ext),
        .sum     (opp_o)
    );
endmodule

// File: rtl/pgom_checker.sv
// Module: pgom_checker
// Property checks for pg_opportunity_monitor, attached by bind below.
// Assumes: observes only top ports plus the window state register.
module pgom_checker #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_start_i,
    input logic             win_end_i,
    input logic             is_open,
    input logic [ACC_W-1:0] total_o,
    input logic [ACC_W-1:0] opp_o,
    input logic             done_o
);
    // R2: start clears both counters on the next cycle.
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_start_i |=> (total_o == '0) && (opp_o == '0));

    // R3: total never decreases within a window.
    p_total_monotonic_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !win_start_i) |=> (total_o >= $past(total_o)));

    // R4: credited cycles never exceed observed cycles.
    p_opp_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        opp_o <= total_o);

    // R7: valid end yields done next cycle, and done lasts one cycle.
    p_done_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && win_end_i && !win_start_i) |=> done_o);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: counters hold while no window is open.
    p_hold_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && !win_start_i) |=> ($stable(total_o) && $stable(opp_o)));

    // R11: end with no window open gives no done pulse.
    p_end_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && !win_start_i) |=> !done_o);
endmodule

bind pg_opportunity_monitor pgom_checker #(.ACC_W(ACC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_start_i (win_start_i),
    .win_end_i   (win_end_i),
    .is_open     (is_open),
    .total_o     (total_o),
    .opp_o       (opp_o),
    .done_o      (done_o)
);

// File: tb/pg_opportunity_monitor_test.sv
module pg_opportunity_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy_i = 1'b0;
    logic [7:0]  overhead_i = '0;
    logic        win_start_i = 1'b0;
    logic        win_end_i = 1'b0;
    logic [31:0] total_o;
    logic [31:0] opp_o;
    logic        done_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc_cnt  = 0;

    pg_opportunity_monitor uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .overhead_i  (overhead_i),
        .win_start_i (win_start_i),
        .win_end_i   (win_end_i),
        .total_o     (total_o),
        .opp_o       (opp_o),
        .done_o      (done_o)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_cnt);
            report();
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input logic b, input int n);
        busy_i = b;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic open_win(input int ovh);
        overhead_i = 8'(ovh);
        win_start_i = 1'b1;
        tick();
        win_start_i = 1'b0;
    endtask

    task automatic close_win();
        win_end_i = 1'b1;
        tick();
        win_end_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 total", total_o, 0);
        check("R1 opp", opp_o, 0);
        check("R1 done", done_o, 0);
    endtask

    task automatic t_example();
        open_win(3);
        check("R2 clear total", total_o, 0);
        run(1, 4); run(0, 5); run(1, 6); run(0, 4); run(1, 4); run(0, 6); run(1, 4);
        close_win();
        check("R7 done", done_o, 1);
        check("R3 total", total_o, 33);
        check("R4 opp", opp_o, 6);
        tick();
        check("R7 done single", done_o, 0);
    endtask

    task automatic t_open_run();
        open_win(2);
        run(1, 3); run(0, 7);
        close_win();
        check("R5 total", total_o, 10);
        check("R5 opp", opp_o, 5);
    endtask

    task automatic t_threshold();
        open_win(5);
        run(0, 5); run(1, 1); run(0, 6); run(1, 1);
        close_win();
        check("R4 threshold total", total_o, 13);
        check("R4 threshold opp", opp_o, 1);
    endtask

    task automatic t_ovh_change();
        open_win(2);
        overhead_i = 8'd10;
        run(0, 6); run(1, 1);
        close_win();
        check("R6 opp", opp_o, 4);
    endtask

    task automatic t_hold();
        open_win(0);
        run(0, 3); run(1, 2); run(0, 4);
        close_win();
        check("R4 zero ovh opp", opp_o, 7);
        check("R3 zero ovh total", total_o, 9);
        run(0, 5); run(1, 3); run(0, 2);
        check("R8 hold total", total_o, 9);
        check("R8 hold opp", opp_o, 7);
        check("R8 no done", done_o, 0);
    endtask

    task automatic t_stray_end();
        close_win();
        check("R11 no done", done_o, 0);
        check("R11 total", total_o, 9);
        check("R11 opp", opp_o, 7);
    endtask

    task automatic t_restart();
        open_win(1);
        run(0, 5);
        open_win(1);
        check("R10 restart total", total_o, 0);
        check("R10 restart opp", opp_o, 0);
        run(0, 2); run(1, 1);
        close_win();
        check("R10 restart final total", total_o, 3);
        check("R10 restart final opp", opp_o, 1);
        // start and end together: start wins
        open_win(0);
        run(0, 4);
        win_end_i = 1'b1;
        open_win(0);
        win_end_i = 1'b0;
        check("R10 both total", total_o, 0);
        check("R10 both no done", done_o, 0);
        run(0, 3);
        close_win();
        check("R10 both final total", total_o, 3);
        check("R10 both final opp", opp_o, 3);
    endtask

    task automatic t_saturate();
        open_win(0);
        run(0, 70000); run(1, 1);
        close_win();
        check("R9 run sat opp", opp_o, 65535);
        check("R9 total", total_o, 70001);
    endtask

    initial begin
        #1;
        t_reset();
        tick(); tick();
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_open_run();
        t_threshold();
        t_ovh_change();
        t_hold();
        t_stray_end();
        t_restart();
        t_saturate();
        report();
    end
endmodule